// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block runs once after reset and loads a configuration image from a three-wire serial EEPROM. It drives chip select, shift clock and data-in, and reads data-out. The part may use either 6-bit or 8-bit word addresses. The block does not need to be told which: it first reads word 0 with a 6-bit address, and an all-ones reply selects 8-bit addressing for everything that follows.

With the width settled, the block reads the first 64 words in ascending order and adds them modulo 2^16. The image counts as good only when that sum equals a fixed constant. From the first three words the block assembles a 48-bit station address. It releases that address, together with a valid flag, an error flag and the detected width, in the cycle of a one-clock done pulse. Each serial access is framed by chip select and timed by a clock divider: the shift clock changes level once every DIV system clocks.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: During an access the data-in line carries 1, 1, 0 and then the word address MSB first, one bit per shift-clock high phase. It is held at 0 for the data phase that follows. Data-in never changes while the shift clock is high.
- R2: Each access collects 16 data bits MSB first. Every bit is taken from data-out at the last system clock of a shift-clock high phase.
- R3: While chip select is high, every shift-clock high level lasts exactly DIV system clocks.
- R4: The first access after reset reads word 0 with a 6-bit address, which takes 25 shift-clock pulses. If the reply is 0xFFFF, 8-bit addressing is used from then on; any other reply keeps 6-bit addressing. addr_wide reads 1 for 8-bit and 0 for 6-bit.
- R5: After that first access the block makes exactly 64 more accesses, to words 0 to 63 in ascending order. Each uses 3 + address width + 16 shift-clock pulses.
- R6: When the 64 words add up to 0xBABA modulo 2^16, cfg_valid is 1 and csum_err is 0.
- R7: When the sum is anything else, csum_err is 1, cfg_valid is 0 and station_addr is all zeros.
- R8: For a good image, station_addr[47:40] is word0[7:0] and [39:32] is word0[15:8]. Bits [31:24] and [23:16] are word1[7:0] and word1[15:8]. Bits [15:8] and [7:0] are word2[7:0] and word2[15:8].
- R9: Before each access, chip select is low for at least DIV system clocks. It rises and falls only while the shift clock is low.
- R10: load_done is high for exactly one clock. Before it, station_addr, cfg_valid, csum_err and addr_wide read 0. From that clock until the next reset they hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; loading starts when it is released |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sk | output | 1 | EEPROM shift clock |
| ee_di | output | 1 | Serial data into the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |
| station_addr | output | 48 | Station address; zero unless the image is good |
| cfg_valid | output | 1 | Image checksum matched |
| csum_err | output | 1 | Image checksum mismatched |
| addr_wide | output | 1 | 1 when 8-bit word addressing was detected |
| load_done | output | 1 | One-clock pulse when the results appear |

## Verification
The loader is run against a behavioural EEPROM in five images:
- A 6-bit part with a good image.
- An 8-bit part whose word 0 is all ones, so the probe reply reads 0xFFFF.
- A 6-bit part whose word 0 is 0xFFFE. This near miss must not switch the width.
- A 6-bit part and an 8-bit part, each with a corrupted checksum word.

The good and bad pairs show whether the result is gated by the checksum. The width cases show whether the probe decision carries into every later access. A wrong width would read the wrong cells and break the sum. Distinct bytes in the first three words expose any byte swap. The address sequence captured on the serial lines shows skipped, repeated or reordered words.

// File: rtl/eecfg_pkg.sv
package eecfg_pkg;

    // Start bit followed by the two-bit read opcode.
    localparam logic [2:0] READ_CMD = 3'b110;
    localparam int         CMD_BITS = 3;

    typedef enum logic [2:0] {
        XF_IDLE,
        XF_GAP,
        XF_LO,
        XF_HI,
        XF_END
    } xfer_state_e;

    typedef enum logic [2:0] {
        SQ_PROBE_GO,
        SQ_PROBE_WAIT,
        SQ_WORD_GO,
        SQ_WORD_WAIT,
        SQ_FINISH,
        SQ_HALT
    } seq_state_e;

endpackage

// File: rtl/eecfg_tick.sv
module eecfg_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (st_q.cnt == CW'(DIV - 1)) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = st_q.tick;

    generate
        if (DIV > 1) begin : g_spacing
            // R3: ticks never come back to back when the divider exceeds one
            a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/eecfg_xfer.sv
module eecfg_xfer
    import eecfg_pkg::*;
#(
    parameter int NARROW_AW = 6,
    parameter int WIDE_AW   = 8,
    parameter int DW        = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               start,
    input  logic               wide,
    input  logic [WIDE_AW-1:0] addr,
    input  logic               ee_do,
    output logic               ee_cs,
    output logic               ee_sk,
    output logic               ee_di,
    output logic               rd_done,
    output logic [DW-1:0]      rd_data
);
    localparam int HDR_MAX = CMD_BITS + WIDE_AW;
    localparam int TOT_MAX = HDR_MAX + DW;
    localparam int BW      = $clog2(TOT_MAX + 1);
    localparam int PAD     = WIDE_AW - NARROW_AW;

    typedef struct packed {
        xfer_state_e        state;
        logic [HDR_MAX-1:0] sh;
        logic [BW-1:0]      bitn;
        logic [BW-1:0]      last;
        logic [DW-1:0]      rx;
        logic               cs;
        logic               sk;
        logic               di;
        logic               done;
    } xfer_st_t;

    xfer_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.state)
            XF_IDLE: begin
                st_d.cs = 1'b0;
                st_d.sk = 1'b0;
                st_d.di = 1'b0;
                if (start) begin
                    st_d.state = XF_GAP;
                    st_d.bitn  = '0;
                    if (wide) begin
                        st_d.sh   = {READ_CMD, addr};
                        st_d.last = BW'(CMD_BITS + WIDE_AW + DW - 1);
                    end else begin
                        st_d.sh   = {READ_CMD, addr[NARROW_AW-1:0], {PAD{1'b0}}};
                        st_d.last = BW'(CMD_BITS + NARROW_AW + DW - 1);
                    end
                end
            end
            XF_GAP: begin
                if (tick) begin
                    st_d.state = XF_LO;
                    st_d.cs    = 1'b1;
                    st_d.di    = st_q.sh[HDR_MAX-1];
                end
            end
            XF_LO: begin
                if (tick) begin
                    st_d.state = XF_HI;
                    st_d.sk    = 1'b1;
                end
            end
            XF_HI: begin
                if (tick) begin
                    if (st_q.bitn > (st_q.last - BW'(DW))) begin
                        st_d.rx = {st_q.rx[DW-2:0], ee_do};
                    end
                    st_d.sh = st_q.sh << 1;
                    st_d.sk = 1'b0;
                    if (st_q.bitn == st_q.last) begin
                        st_d.state = XF_END;
                        st_d.cs    = 1'b0;
                        st_d.di    = 1'b0;
                    end else begin
                        st_d.state = XF_LO;
                        st_d.bitn  = st_q.bitn + 1'b1;
                        st_d.di    = st_d.sh[HDR_MAX-1];
                    end
                end
            end
            XF_END: begin
                if (tick) begin
                    st_d.state = XF_IDLE;
                    st_d.done  = 1'b1;
                end
            end
            default: st_d.state = XF_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ee_cs   = st_q.cs;
    assign ee_sk   = st_q.sk;
    assign ee_di   = st_q.di;
    assign rd_done = st_q.done;
    assign rd_data = st_q.rx;

    // R1: data-in only moves while the shift clock is low
    a_r1_di_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ee_di) |-> !ee_sk);

    // R3: every shift clock edge is paced by the divider tick
    a_r3_sk_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ee_sk) |-> $past(tick));

    // R9: chip select edges only with the shift clock low
    a_r9_cs_rise_sk_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_cs) |-> !ee_sk);
    a_r9_cs_fall_sk_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ee_cs) |-> !ee_sk);

    // R2: completion of one read is a single-cycle event
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);

endmodule

// File: rtl/eecfg_seq.sv
module eecfg_seq
    import eecfg_pkg::*;
#(
    parameter int          NWORDS   = 64,
    parameter int          WIDE_AW  = 8,
    parameter int          DW       = 16,
    parameter int          SA_WORDS = 3,
    parameter logic [15:0] CSUM     = 16'hBABA
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_done,
    input  logic [DW-1:0]          rd_data,
    output logic                   rd_start,
    output logic                   rd_wide,
    output logic [WIDE_AW-1:0]     rd_addr,
    output logic [SA_WORDS*DW-1:0] station_addr,
    output logic                   cfg_valid,
    output logic                   csum_err,
    output logic                   addr_wide,
    output logic                   load_done
);
    localparam int IW  = $clog2(NWORDS);
    localparam int SAW = SA_WORDS * DW;
    localparam int HB  = DW / 2;

    typedef struct packed {
        seq_state_e                   state;
        logic [IW-1:0]                idx;
        logic                         wide;
        logic [DW-1:0]                sum;
        logic [SA_WORDS-1:0][DW-1:0]  raw;
        logic [SAW-1:0]               station;
        logic                         valid;
        logic                         err;
        logic                         wide_out;
        logic                         done;
    } seq_st_t;

    seq_st_t        st_d, st_q;
    logic [SAW-1:0] packed_sa;
    logic           sum_ok;

    // Low byte of each word goes out first, word 0 leading.
    always_comb begin
        packed_sa = '0;
        for (int w = 0; w < SA_WORDS; w++) begin
            packed_sa[SAW-1-DW*w -: DW] = {st_q.raw[w][HB-1:0], st_q.raw[w][DW-1:HB]};
        end
    end

    assign sum_ok = (st_q.sum == CSUM[DW-1:0]);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.state)
            SQ_PROBE_GO:   st_d.state = SQ_PROBE_WAIT;
            SQ_PROBE_WAIT: begin
                if (rd_done) begin
                    st_d.wide  = (rd_data == {DW{1'b1}});
                    st_d.idx   = '0;
                    st_d.state = SQ_WORD_GO;
                end
            end
            SQ_WORD_GO:    st_d.state = SQ_WORD_WAIT;
            SQ_WORD_WAIT: begin
                if (rd_done) begin
                    st_d.sum = st_q.sum + rd_data;
                    for (int w = 0; w < SA_WORDS; w++) begin
                        if (st_q.idx == IW'(w)) st_d.raw[w] = rd_data;
                    end
                    if (st_q.idx == IW'(NWORDS - 1)) begin
                        st_d.state = SQ_FINISH;
                    end else begin
                        st_d.idx   = st_q.idx + 1'b1;
                        st_d.state = SQ_WORD_GO;
                    end
                end
            end
            SQ_FINISH: begin
                st_d.valid    = sum_ok;
                st_d.err      = !sum_ok;
                st_d.station  = sum_ok ? packed_sa : '0;
                st_d.wide_out = st_q.wide;
                st_d.done     = 1'b1;
                st_d.state    = SQ_HALT;
            end
            SQ_HALT:  st_d.state = SQ_HALT;
            default:  st_d.state = SQ_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_start     = (st_q.state == SQ_PROBE_GO) || (st_q.state == SQ_WORD_GO);
    assign rd_wide      = st_q.wide;
    assign rd_addr      = WIDE_AW'(st_q.idx);
    assign station_addr = st_q.station;
    assign cfg_valid    = st_q.valid;
    assign csum_err     = st_q.err;
    assign addr_wide    = st_q.wide_out;
    assign load_done    = st_q.done;

    // R7: a rejected image never exposes address bytes
    a_r7_zero_on_error: assert property (@(posedge clk) disable iff (!rst_n)
        csum_err |-> (station_addr == '0));

    // R6: the two verdict flags never coexist
    a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_valid && csum_err));

    // R10: done lasts one clock, results then freeze
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> !load_done);
    a_r10_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid || csum_err) && !load_done |->
            $stable(station_addr) && $stable(cfg_valid) && $stable(csum_err) && $stable(addr_wide));

    // R4: the probe read always uses the short address
    a_r4_probe_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == SQ_PROBE_GO) |-> (!rd_wide && rd_addr == '0));

endmodule

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader #(
    parameter int          DIV       = 4,
    parameter int          NWORDS    = 64,
    parameter int          NARROW_AW = 6,
    parameter int          WIDE_AW   = 8,
    parameter int          DW        = 16,
    parameter int          SA_WORDS  = 3,
    parameter logic [15:0] CSUM      = 16'hBABA
) (
    input  logic                   clk,
    input  logic                   rst_n,
    output logic                   ee_cs,
    output logic                   ee_sk,
    output logic                   ee_di,
    input  logic                   ee_do,
    output logic [SA_WORDS*DW-1:0] station_addr,
    output logic                   cfg_valid,
    output logic                   csum_err,
    output logic                   addr_wide,
    output logic                   load_done
);
    logic               tick;
    logic               rd_start;
    logic               rd_wide;
    logic [WIDE_AW-1:0] rd_addr;
    logic               rd_done;
    logic [DW-1:0]      rd_data;

    eecfg_tick #(.DIV(DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    eecfg_xfer #(
        .NARROW_AW (NARROW_AW),
        .WIDE_AW   (WIDE_AW),
        .DW        (DW)
    ) u_xfer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .start   (rd_start),
        .wide    (rd_wide),
        .addr    (rd_addr),
        .ee_do   (ee_do),
        .ee_cs   (ee_cs),
        .ee_sk   (ee_sk),
        .ee_di   (ee_di),
        .rd_done (rd_done),
        .rd_data (rd_data)
    );

    eecfg_seq #(
        .NWORDS   (NWORDS),
        .WIDE_AW  (WIDE_AW),
        .DW       (DW),
        .SA_WORDS (SA_WORDS),
        .CSUM     (CSUM)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_done      (rd_done),
        .rd_data      (rd_data),
        .rd_start     (rd_start),
        .rd_wide      (rd_wide),
        .rd_addr      (rd_addr),
        .station_addr (station_addr),
        .cfg_valid    (cfg_valid),
        .csum_err     (csum_err),
        .addr_wide    (addr_wide),
        .load_done    (load_done)
    );

    // R5: a new read is only requested while the serial engine is idle
    a_r5_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |-> !ee_cs);

endmodule

// File: tb/eeprom_cfg_loader_tb.sv
module eeprom_cfg_loader_tb_top;
    localparam int DIV = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ee_cs, ee_sk, ee_di;
    logic        ee_do = 1'b1;
    logic [47:0] station_addr;
    logic        cfg_valid, csum_err, addr_wide, load_done;

    always #2 clk = ~clk;

    eeprom_cfg_loader #(.DIV(DIV)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ee_cs        (ee_cs),
        .ee_sk        (ee_sk),
        .ee_di        (ee_di),
        .ee_do        (ee_do),
        .station_addr (station_addr),
        .cfg_valid    (cfg_valid),
        .csum_err     (csum_err),
        .addr_wide    (addr_wide),
        .load_done    (load_done)
    );

    int vectors = 0;
    int miscompares = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural EEPROM ----------------
    logic [15:0] mem [256];
    bit          m_wide;
    int          m_cnt = 0;
    logic [7:0]  m_addr = '0;

    always @(negedge ee_cs) begin
        m_cnt  = 0;
        m_addr = '0;
        ee_do  = 1'b1;
    end

    always @(posedge ee_sk) begin
        if (ee_cs === 1'b1) begin
            m_cnt++;
            if (m_cnt > 3 && m_cnt <= 3 + (m_wide ? 8 : 6))
                m_addr = {m_addr[6:0], ee_di};
            if (m_cnt > 3 + (m_wide ? 8 : 6) && m_cnt <= 19 + (m_wide ? 8 : 6))
                ee_do = mem[m_addr][15 - (m_cnt - 4 - (m_wide ? 8 : 6))];
            else
                ee_do = 1'b1;
        end
    end

    // ---------------- serial line monitor ----------------
    bit          mon_on = 0;
    int          cur_edges = 0;
    logic [31:0] cur_bits = '0;
    int          acc_edges[$];
    logic [31:0] acc_bits[$];

    always @(posedge ee_sk) begin
        if (mon_on && ee_cs === 1'b1) begin
            cur_edges++;
            cur_bits = {cur_bits[30:0], ee_di};
        end
    end

    always @(negedge ee_cs) begin
        if (mon_on && cur_edges > 0) begin
            acc_edges.push_back(cur_edges);
            acc_bits.push_back(cur_bits);
        end
        cur_edges = 0;
        cur_bits  = '0;
    end

    // ---------------- per-clock reference comparison ----------------
    bit          seen_done;
    bit          exp_wide, exp_valid;
    logic [47:0] exp_station;
    logic        prev_sk, prev_cs, prev_di;
    int          hi_run, cs_lo_run;

    always @(negedge clk) begin
        if (mon_on) begin
            // R1: data-in frozen while the shift clock is high
            if (ee_sk === 1'b1 && prev_sk === 1'b1 && ee_di !== prev_di)
                chk(1'b0, "R1 data-in moved with shift clock high", 64'(ee_di), 64'(prev_di));
            // R3: high phase length
            if (ee_sk === 1'b1) hi_run++;
            else begin
                if (prev_sk === 1'b1) chk(hi_run == DIV, "R3 shift clock high length", 64'(hi_run), 64'(DIV));
                hi_run = 0;
            end
            // R9: idle gap before each access, shift clock low at select
            if (ee_cs !== 1'b1) cs_lo_run++;
            else begin
                if (prev_cs !== 1'b1) begin
                    chk(cs_lo_run >= DIV, "R9 select low gap", 64'(cs_lo_run), 64'(DIV));
                    chk(ee_sk === 1'b0, "R9 shift clock low at select", 64'(ee_sk), 64'd0);
                end
                cs_lo_run = 0;
            end
            // outputs
            if (!seen_done) begin
                if (load_done === 1'b1) begin
                    chk(addr_wide === exp_wide, "R4 detected width", 64'(addr_wide), 64'(exp_wide));
                    chk({cfg_valid, csum_err} === {exp_valid, !exp_valid},
                        exp_valid ? "R6 checksum verdict" : "R7 checksum verdict",
                        64'({cfg_valid, csum_err}), 64'({exp_valid, !exp_valid}));
                    chk(station_addr === exp_station,
                        exp_valid ? "R8 station bytes (R2 bit order)" : "R7 station forced to zero",
                        64'(station_addr), 64'(exp_station));
                    seen_done = 1;
                end else begin
                    chk({cfg_valid, csum_err, addr_wide, station_addr} === 51'd0,
                        "R10 results zero before done",
                        64'({cfg_valid, csum_err, addr_wide, station_addr}), 64'd0);
                end
            end else begin
                chk(load_done === 1'b0 && station_addr === exp_station && addr_wide === exp_wide &&
                    cfg_valid === exp_valid && csum_err === !exp_valid,
                    "R10 single pulse and held results",
                    64'({load_done, cfg_valid, csum_err, addr_wide, station_addr}),
                    64'({1'b0, exp_valid, !exp_valid, exp_wide, exp_station}));
            end
            prev_sk = ee_sk;
            prev_cs = ee_cs;
            prev_di = ee_di;
        end
    end

    // ---------------- one test case ----------------
    task automatic run_case(input bit wide_part, input int kind);
        logic [15:0] s;
        logic [15:0] probe;
        int          aw;
        m_wide = wide_part;
        for (int i = 0; i < 256; i++) mem[i] = 16'hC0DE ^ 16'(i * 7);
        case (kind)
            1, 3: begin mem[0] = 16'hFFFF; mem[1] = 16'hA1B2; mem[2] = 16'hC3D4; end
            4:    begin mem[0] = 16'hFFFE; mem[1] = 16'h0102; mem[2] = 16'h0304; end
            default: begin mem[0] = 16'h2211; mem[1] = 16'h4433; mem[2] = 16'h6655; end
        endcase
        for (int i = 3; i < 63; i++) mem[i] = 16'(i * 16'h0B3D + 16'h1234);
        s = '0;
        for (int i = 0; i < 63; i++) s = s + mem[i];
        mem[63] = 16'hBABA - s;
        if (kind == 2 || kind == 3) mem[63] = mem[63] ^ 16'h0100;

        probe    = wide_part ? {2'b11, mem[0][15:2]} : mem[0];
        exp_wide = (probe == 16'hFFFF);
        s = '0;
        for (int i = 0; i < 64; i++) s = s + mem[i];
        exp_valid   = (s == 16'hBABA);
        exp_station = exp_valid ? {mem[0][7:0], mem[0][15:8], mem[1][7:0], mem[1][15:8],
                                   mem[2][7:0], mem[2][15:8]} : 48'd0;

        rst_n  = 1'b0;
        mon_on = 0;
        acc_edges.delete();
        acc_bits.delete();
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk({ee_cs, ee_sk, load_done, cfg_valid, csum_err, addr_wide, station_addr} === 54'd0,
            "R10 reset state", 64'({ee_cs, ee_sk, load_done, cfg_valid, csum_err, addr_wide, station_addr}), 64'd0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        seen_done = 0;
        hi_run    = 0;
        cs_lo_run = 0;
        prev_sk   = ee_sk;
        prev_cs   = ee_cs;
        prev_di   = ee_di;
        cur_edges = 0;
        cur_bits  = '0;
        mon_on    = 1;
        for (int c = 0; c < 20000 && !seen_done; c++) @(negedge clk);
        if (!seen_done) chk(1'b0, "R10 watchdog, no done pulse", 64'd0, 64'd1);
        repeat (40) @(negedge clk);
        #1;
        mon_on = 0;

        chk(acc_edges.size() == 65, "R5 access count", 64'(acc_edges.size()), 64'd65);
        if (acc_edges.size() == 65) begin
            chk(acc_edges[0] == 25, "R4 probe pulse count", 64'(acc_edges[0]), 64'd25);
            chk((acc_bits[0] >> 16) == 32'h180, "R4 probe header 110 + address 0",
                64'(acc_bits[0] >> 16), 64'h180);
            aw = exp_wide ? 8 : 6;
            for (int k = 1; k < 65; k++) begin
                chk(acc_edges[k] == 19 + aw, "R5 pulses per word read", 64'(acc_edges[k]), 64'(19 + aw));
                chk((acc_bits[k] >> 16) == ((32'd6 << aw) | 32'(k - 1)), "R5 ascending address, R1 header",
                    64'(acc_bits[k] >> 16), 64'((32'd6 << aw) | 32'(k - 1)));
                chk(acc_bits[k][15:0] == 16'h0, "R1 data-in low during data phase",
                    64'(acc_bits[k][15:0]), 64'd0);
            end
        end
    endtask

    initial begin
        run_case(1'b0, 0);   // narrow part, good image
        run_case(1'b1, 1);   // wide part, word 0 all ones, good image
        run_case(1'b0, 2);   // narrow part, bad checksum
        run_case(1'b1, 3);   // wide part, bad checksum
        run_case(1'b0, 4);   // narrow part, word 0 = 0xFFFE must stay narrow
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule